// File: doc/BRIEF.md
# Packed Halfword Saturation Unit

This unit clamps the two signed 16-bit halves of a 32-bit source word into a bit range that the instruction word selects. A signed form clamps each half to a symmetric two's-complement range. An unsigned form clamps each half to the range from zero up to a power of two minus one. The two clamped halves are packed back into a 32-bit result in the positions they came from.

A saturation flag records that clipping happened. The flag is cumulative: it goes high when either half of an accepted operation is clipped, and it stays high until a clear strobe or reset. The unit sits beside an execution stage. The stage presents the instruction word and the already-read source operand with a valid strobe. One cycle later the unit returns the packed result, a result-valid pulse and the destination register index, which it takes from the instruction.

Top module: `dual_lane_clamp`

## Requirements
- R1: An operation is accepted only when `in_valid` is high, instruction bits 27:20 equal 8'h6A (signed form) or 8'h6E (unsigned form), and instruction bits 7:5 equal 3'b001. Any other cycle leaves `res_valid` low, `res_data` and `dest_idx` unchanged, and `sat_flag` unaffected.
- R2: In the signed form, with f = instruction bits 19:16, each half is clamped to the range -2^f through 2^f-1. This gives saturation widths of 1 to 16 bits. With f = 15 no value is clipped.
- R3: In the unsigned form, with f = instruction bits 19:16, each half is clamped to the range 0 through 2^f-1. With f = 0 every half becomes 0, and any nonzero half counts as clipped.
- R4: Source bits 15:0 and 31:16 are each read as signed 16-bit values and clamped independently. The clamped low half goes to result bits 15:0 and the clamped high half to result bits 31:16.
- R5: `sat_flag` is set one cycle after an accepted operation in which either half lay above its maximum or below its minimum.
- R6: `sat_flag` is sticky. An accepted operation with no clipping, or an idle cycle, does not lower it.
- R7: `flag_clr` lowers `sat_flag` on the next cycle. When `flag_clr` coincides with an accepted operation that clips, the flag ends up set.
- R8: `res_valid` pulses high for exactly the cycle after each accepted operation. `res_data` and `dest_idx` (instruction bits 15:12) update on that same edge and hold between operations.
- R9: After a synchronous reset, `res_valid`, `res_data`, `dest_idx` and `sat_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operand are presented this cycle |
| instr | input | 32 | Instruction word |
| src_word | input | 32 | Source operand holding the two halves |
| flag_clr | input | 1 | Clear strobe for the sticky saturation flag |
| res_data | output | 32 | Packed clamped result |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| dest_idx | output | 4 | Destination register index of the last result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
A wrong limit inside one lane shows up on the next cycle as a result half that sits outside its range or differs from the arithmetic clamp. The sweep therefore probes every width code in both forms at the exact limit, one past it, and the extreme 16-bit values. A corrupted flag state does not always show at once, because a later clipping operation can mask a lost bit. For that reason the flag is compared after every single operation, across runs of non-clipping operations and around clear strobes. A decode error either yields a spurious `res_valid` pulse or changes the held result on a rejected cycle. Both are visible on the cycle after the stimulus.

// File: rtl/lane_clamp_pkg.sv
package lane_clamp_pkg;
  // Primary opcode byte, instruction bits 27:20
  localparam logic [7:0] OPC_SIGNED   = 8'h6A;
  localparam logic [7:0] OPC_UNSIGNED = 8'h6E;
  // Sub-operation code, instruction bits 7:5
  localparam logic [2:0] SUBOP_PAIR   = 3'b001;
  // Field positions inside the instruction word
  localparam int OPC_LSB  = 20;
  localparam int FLD_LSB  = 16;
  localparam int DEST_LSB = 12;
  localparam int SUB_LSB  = 5;
endpackage

// File: rtl/clamp_decode.sv
module clamp_decode
  import lane_clamp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 4,
  parameter int FLD_W  = 4
) (
  input  logic              in_valid,
  input  logic [WORD_W-1:0] instr,
  output logic              hit,
  output logic              is_signed,
  output logic [FLD_W-1:0]  width_fld,
  output logic [IDX_W-1:0]  dest
);
  logic [7:0] opc;
  logic [2:0] sub;

  always_comb begin
    opc       = instr[OPC_LSB +: 8];
    sub       = instr[SUB_LSB +: 3];
    is_signed = (opc == OPC_SIGNED);
    hit       = in_valid && sub == SUBOP_PAIR &&
                (opc == OPC_SIGNED || opc == OPC_UNSIGNED);
    width_fld = instr[FLD_LSB +: FLD_W];
    dest      = instr[DEST_LSB +: IDX_W];
  end
endmodule

// File: rtl/lane_clamp.sv
module lane_clamp #(
  parameter int LANE_W = 16,
  parameter int FLD_W  = 4
) (
  input  logic [LANE_W-1:0] lane_in,
  input  logic              is_signed,
  input  logic [FLD_W-1:0]  width_fld,
  output logic [LANE_W-1:0] lane_out,
  output logic              clipped
);
  localparam int EXT_W = LANE_W + 2;

  logic signed [EXT_W-1:0] val, step, top_lim, bot_lim, out_ext;

  always_comb begin
    val     = $signed({{2{lane_in[LANE_W-1]}}, lane_in});
    step    = $signed({{(EXT_W-1){1'b0}}, 1'b1} << width_fld);
    top_lim = step - 1;
    bot_lim = is_signed ? -step : '0;
    if (val > top_lim) begin
      lane_out = top_lim[LANE_W-1:0];
      clipped  = 1'b1;
    end else if (val < bot_lim) begin
      lane_out = bot_lim[LANE_W-1:0];
      clipped  = 1'b1;
    end else begin
      lane_out = lane_in;
      clipped  = 1'b0;
    end
  end

  // R2 / R3: the clamped half always lies inside the selected range
  always_comb begin
    out_ext = $signed({{2{lane_out[LANE_W-1]}}, lane_out});
    a_r2_lane_in_range: assert (out_ext <= top_lim && out_ext >= bot_lim)
      else $error("clamped half outside range");
  end
endmodule

// File: rtl/dual_lane_clamp.sv
module dual_lane_clamp #(
  parameter int WORD_W = 32,
  parameter int LANES  = 2,
  parameter int IDX_W  = 4,
  parameter int FLD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] src_word,
  input  logic              flag_clr,
  output logic [WORD_W-1:0] res_data,
  output logic              res_valid,
  output logic [IDX_W-1:0]  dest_idx,
  output logic              sat_flag
);
  localparam int LANE_W = WORD_W / LANES;

  logic              hit, is_signed;
  logic [FLD_W-1:0]  width_fld;
  logic [IDX_W-1:0]  dest;
  logic [WORD_W-1:0] packed_w;
  logic [LANES-1:0]  clip_vec;
  logic              clip_any;

  clamp_decode #(.WORD_W(WORD_W), .IDX_W(IDX_W), .FLD_W(FLD_W)) u_dec (
    .in_valid (in_valid),
    .instr    (instr),
    .hit      (hit),
    .is_signed(is_signed),
    .width_fld(width_fld),
    .dest     (dest)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_clamp #(.LANE_W(LANE_W), .FLD_W(FLD_W)) u_lane (
      .lane_in  (src_word[g*LANE_W +: LANE_W]),
      .is_signed(is_signed),
      .width_fld(width_fld),
      .lane_out (packed_w[g*LANE_W +: LANE_W]),
      .clipped  (clip_vec[g])
    );
  end

  assign clip_any = |clip_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      dest_idx  <= '0;
      sat_flag  <= 1'b0;
    end else begin
      res_valid <= hit;
      if (hit) begin
        res_data <= packed_w;
        dest_idx <= dest;
      end
      sat_flag <= (sat_flag & ~flag_clr) | (hit & clip_any);
    end
  end

  // R8: a result pulse follows every accepted operation
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    hit |=> res_valid);
  // R1 / R8: no pulse without an accepted operation
  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !hit |=> !res_valid);
  // R1: rejected cycles keep the result and index
  a_r1_hold_result: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(res_data) && $stable(dest_idx)));
  // R6: the flag only drops on a clear strobe
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !flag_clr) |=> sat_flag);
  // R7: a clear without a clipping operation lowers the flag
  a_r7_flag_cleared: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !(hit && clip_any)) |=> !sat_flag);
  // R5: a clipping operation raises the flag
  a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
    (hit && clip_any) |=> sat_flag);
endmodule

// File: tb/test_dual_lane_clamp.sv
module test_dual_lane_clamp;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src_word = '0;
  logic        flag_clr = 1'b0;
  logic [31:0] res_data;
  logic        res_valid;
  logic [3:0]  dest_idx;
  logic        sat_flag;

  int checks = 0;
  int errors = 0;
  bit exp_flag = 1'b0;
  logic [31:0] exp_res = '0;
  logic [3:0]  exp_dest = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_lane_clamp i_dual_lane_clamp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_word(src_word), .flag_clr(flag_clr), .res_data(res_data),
    .res_valid(res_valid), .dest_idx(dest_idx), .sat_flag(sat_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] clamp_ref(input logic [15:0] v, input bit sgn,
                                            input int f, output bit c);
    int sv, hi, lo;
    sv = int'($signed(v));
    hi = (1 << f) - 1;
    lo = sgn ? -(1 << f) : 0;
    c  = 1'b0;
    if (sv > hi) begin sv = hi; c = 1'b1; end
    else if (sv < lo) begin sv = lo; c = 1'b1; end
    return sv[15:0];
  endfunction

  function automatic logic [15:0] pick(input int k, input bit sgn, input int f);
    int hi, lo, x;
    hi = (1 << f) - 1;
    lo = sgn ? -(1 << f) : 0;
    case (k)
      0: x = 0;
      1: x = 1;
      2: x = -1;
      3: x = hi;
      4: x = hi + 1;
      5: x = lo;
      6: x = lo - 1;
      7: x = 32767;
      8: x = -32768;
      9: x = hi - 1;
      10: x = (f * 2731 + 97) % 65536;
      default: x = -((f * 401 + 13) % 30000);
    endcase
    return x[15:0];
  endfunction

  // Drive one cycle at a falling edge, then return at the next falling edge
  task automatic cycle(input bit v, input logic [31:0] ins, input logic [31:0] src, input bit clr);
    @(negedge clk);
    in_valid = v; instr = ins; src_word = src; flag_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 res_valid", {31'b0, res_valid}, 32'h0);
    check("R9 res_data", res_data, 32'h0);
    check("R9 dest_idx", {28'b0, dest_idx}, 32'h0);
    check("R9 sat_flag", {31'b0, sat_flag}, 32'h0);
    rst = 1'b0;

    for (int m = 0; m < 2; m++) begin
      for (int f = 0; f < 16; f++) begin
        bit sgn;
        sgn = (m == 0);
        // R7 clear-only cycle
        cycle(1'b0, '0, '0, 1'b1);
        exp_flag = 1'b0;
        check("R7 clear", {31'b0, sat_flag}, 32'h0);
        for (int k = 0; k < 12; k++) begin
          logic [15:0] lo_v, hi_v, lo_e, hi_e;
          logic [31:0] ins;
          bit c0, c1, clr;
          lo_v = pick(k, sgn, f);
          hi_v = pick((k + 4) % 12, sgn, f);
          lo_e = clamp_ref(lo_v, sgn, f, c0);
          hi_e = clamp_ref(hi_v, sgn, f, c1);
          ins = {4'hE, (sgn ? 8'h6A : 8'h6E), f[3:0], 4'((k + f) % 16), 4'h0, 3'b001, 1'b1, 4'(k)};
          clr = (k == 11);
          cycle(1'b1, ins, {hi_v, lo_v}, clr);
          exp_res  = {hi_e, lo_e};
          exp_dest = 4'((k + f) % 16);
          if (clr) exp_flag = 1'b0;
          exp_flag = exp_flag | c0 | c1;
          // R2 signed / R3 unsigned / R4 lane packing
          check(sgn ? "R2 R4 result" : "R3 R4 result", res_data, exp_res);
          check("R8 valid and dest", {27'b0, res_valid, dest_idx}, {27'b0, 1'b1, exp_dest});
          // R5 set, R6 sticky, R7 clear with same-cycle clip
          check("R5 R6 R7 flag", {31'b0, sat_flag}, {31'b0, exp_flag});
        end
      end
    end

    // R1: rejected cycles, with flag set beforehand and clipping operands
    cycle(1'b1, {4'hE, 8'h6E, 4'h0, 4'h3, 4'h0, 3'b001, 1'b1, 4'h1}, 32'h8000_7FFF, 1'b0);
    exp_res = 32'h0; exp_dest = 4'h3; exp_flag = 1'b1;
    check("R3 zero width", res_data, exp_res);
    // wrong sub-operation code
    cycle(1'b1, {4'hE, 8'h6E, 4'h5, 4'h9, 4'h0, 3'b011, 1'b1, 4'h1}, 32'h1234_5678, 1'b0);
    check("R1 subop ignored valid", {31'b0, res_valid}, 32'h0);
    check("R1 subop ignored data", res_data, exp_res);
    check("R1 subop ignored dest", {28'b0, dest_idx}, {28'b0, exp_dest});
    // wrong opcode byte
    cycle(1'b1, {4'hE, 8'h6B, 4'h5, 4'h9, 4'h0, 3'b001, 1'b1, 4'h1}, 32'h1234_5678, 1'b0);
    check("R1 opcode ignored valid", {31'b0, res_valid}, 32'h0);
    check("R1 opcode ignored data", res_data, exp_res);
    // valid low with a matching word
    cycle(1'b0, {4'hE, 8'h6A, 4'h2, 4'h9, 4'h0, 3'b001, 1'b1, 4'h1}, 32'h1234_5678, 1'b0);
    check("R1 no strobe valid", {31'b0, res_valid}, 32'h0);
    check("R1 no strobe data", res_data, exp_res);
    check("R6 flag held idle", {31'b0, sat_flag}, 32'h1);
    // clipping operand on a rejected cycle must not set a cleared flag
    cycle(1'b0, '0, '0, 1'b1);
    cycle(1'b1, {4'hE, 8'h6A, 4'h0, 4'h9, 4'h0, 3'b010, 1'b1, 4'h1}, 32'h7FFF_8000, 1'b0);
    check("R1 rejected no flag", {31'b0, sat_flag}, 32'h0);
    // non-clipping accepted op keeps flag state; then one-cycle pulse
    cycle(1'b1, {4'hE, 8'h6A, 4'hF, 4'h7, 4'h0, 3'b001, 1'b1, 4'h1}, 32'h8000_7FFF, 1'b0);
    check("R2 full width passthrough", res_data, 32'h8000_7FFF);
    check("R5 no clip no flag", {31'b0, sat_flag}, 32'h0);
    @(negedge clk);
    check("R8 pulse one cycle", {31'b0, res_valid}, 32'h0);
    check("R8 data held", res_data, 32'h8000_7FFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule